// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash device. After a program or erase command has been sent, it decides whether the operation has finished. It reads the device status byte over a read request/acknowledge handshake and compares a toggle bit between two reads taken back to back. It also watches the device's time-limit-exceeded status bit. When it finds that the device has failed, it sends a reset command over a separate write handshake. Bus timing belongs to the handshake agents and is not part of this block.

A one-cycle `start` pulse launches a poll. The block returns a one-cycle `done` pulse together with a two-bit result. The result stays readable until the next launch. An `abort` input ends a poll at once. A later launch always begins again from a fresh pair of reads.

If the time-limit bit is seen high while the toggle bit is still changing, the block does not report failure straight away. It first takes one more pair of reads. The toggle bit may have settled in the same instant the time-limit bit rose.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: During and after reset, `busy`, `rdReq`, `wrReq`, `done` and `arrayReadOk` are low and `result` is 2'b00 (none).
- R2: A `start` pulse while idle raises `busy` and `rdReq`. The first acknowledged read of a pair stores the monitored toggle bit, and the second read is compared against it.
- R3: If the monitored bit is equal in both reads of a pair, `done` pulses with `result` 2'b01 (success) in the cycle after the second read's acknowledge, and `arrayReadOk` goes high. `arrayReadOk` is cleared when the next `start` is accepted.
- R4: If the bit differs and bit 5 of the pair's second read is low, a new pair of reads follows.
- R5: If the bit differs and bit 5 of the pair's second read is high, exactly one re-check pair is read. If the bit is equal in that pair, the result is success and no write is issued.
- R6: If the re-check pair still differs, exactly one write of 8'hF0 is requested. After its acknowledge, `done` pulses with `result` 2'b10 (device error).
- R7: With POLL_LIMIT = N > 0, the Nth consecutive differing pair with bit 5 low ends the poll with `result` 2'b11 (timeout). This takes 2N reads and issues no write.
- R8: `abort` returns the block to idle in the next cycle with all requests low. No `done` follows, even when `abort` coincides with the acknowledge that would have completed the poll.
- R9: A poll launched after an abort starts with a fresh pair of reads, and its poll count starts from zero.
- R10: Only the bit chosen by TOGGLE_BIT (default 6) is compared. A change in any other status bit, such as bit 2, does not count as toggling.
- R11: `done` lasts exactly one cycle. `result` holds its value until the next start. A `start` pulse while busy is ignored.
- R12: `rdReq` and `wrReq` are never high together, and `wrData` is 8'hF0 whenever a write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a poll (ignored while busy) |
| abort | input | 1 | Abandon the running poll |
| rdReq | output | 1 | Status read request, held until acknowledged |
| rdAck | input | 1 | Read acknowledge; rdData valid with it |
| rdData | input | 8 | Status byte returned by the read |
| wrReq | output | 1 | Reset-command write request |
| wrAck | input | 1 | Write acknowledge |
| wrData | output | 8 | Write data (reset command) |
| busy | output | 1 | A poll is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 none, 01 success, 10 device error, 11 timeout |
| arrayReadOk | output | 1 | Last poll succeeded; array reads allowed |

## Verification
Abort and completion can fall in the same cycle. The read acknowledge that would finish a poll can arrive in the same clock as `abort`. The bench provokes this by raising `abort` just after its read responder has set the acknowledge for the second read of a poll that would otherwise succeed. It then checks over the following cycles that `done` never pulses, that `arrayReadOk` stays low and that `busy` drops. A fresh poll launched afterwards must get its full poll-count budget.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;

  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_OK      = 2'b01,
    RES_DEVERR  = 2'b10,
    RES_TIMEOUT = 2'b11
  } pollRes_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_CHK_A,
    ST_CHK_B,
    ST_RST_WR
  } pollSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     capFirst;
    logic     clrCnt;
    logic     incCnt;
    logic     clrOk;
    logic     finish;
    pollRes_e code;
  } dpCtl_t;

  localparam logic [7:0] RESET_CMD = 8'hF0;

endpackage

// File: rtl/toggle_poll_dp.sv
module toggle_poll_dp
  import toggle_poll_pkg::*;
#(
  parameter int DW         = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int FAIL_BIT   = 5,
  parameter int POLL_LIMIT = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [DW-1:0] rdData,
  output logic          toggled,
  output logic          failBitHi,
  output logic          limitHit,
  output logic          done,
  output pollRes_e      result,
  output logic          arrayReadOk
);

  localparam int CNT_W = (POLL_LIMIT > 2) ? $clog2(POLL_LIMIT) : 1;

  logic firstBit;

  always_ff @(posedge clk) begin
    if (!rstN) firstBit <= 1'b0;
    else if (ctl.capFirst) firstBit <= rdData[TOGGLE_BIT];
  end

  assign toggled   = rdData[TOGGLE_BIT] != firstBit;
  assign failBitHi = rdData[FAIL_BIT];

  generate
    if (POLL_LIMIT > 0) begin : g_lim
      logic [CNT_W-1:0] pollCnt;
      always_ff @(posedge clk) begin
        if (!rstN || ctl.clrCnt) pollCnt <= '0;
        else if (ctl.incCnt)     pollCnt <= pollCnt + 1'b1;
      end
      assign limitHit = (pollCnt == CNT_W'(POLL_LIMIT - 1));
    end else begin : g_nolim
      assign limitHit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done        <= 1'b0;
      result      <= RES_NONE;
      arrayReadOk <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.finish) begin
        result      <= ctl.code;
        arrayReadOk <= (ctl.code == RES_OK);
      end else if (ctl.clrOk) begin
        arrayReadOk <= 1'b0;
      end
    end
  end

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R11
  done_code_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> result != RES_NONE);
  // R3
  ok_flag_chk: assert property (@(posedge clk) disable iff (!rstN) arrayReadOk |-> result == RES_OK);

endmodule

// File: rtl/toggle_poll_fsm.sv
module toggle_poll_fsm
  import toggle_poll_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   abort,
  input  logic   rdAck,
  input  logic   wrAck,
  input  logic   toggled,
  input  logic   failBitHi,
  input  logic   limitHit,
  output dpCtl_t ctl,
  output logic   rdReq,
  output logic   wrReq,
  output logic   busy
);

  pollSt_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.clrCnt = 1'b1;
        ctl.clrOk  = 1'b1;
        nextState  = ST_RD_A;
      end
      ST_RD_A: if (rdAck) begin
        ctl.capFirst = 1'b1;
        nextState    = ST_RD_B;
      end
      ST_RD_B: if (rdAck) begin
        if (!toggled) begin
          ctl.finish = 1'b1;
          ctl.code   = RES_OK;
          nextState  = ST_IDLE;
        end else if (failBitHi) begin
          nextState = ST_CHK_A;
        end else if (limitHit) begin
          ctl.finish = 1'b1;
          ctl.code   = RES_TIMEOUT;
          nextState  = ST_IDLE;
        end else begin
          ctl.incCnt = 1'b1;
          nextState  = ST_RD_A;
        end
      end
      ST_CHK_A: if (rdAck) begin
        ctl.capFirst = 1'b1;
        nextState    = ST_CHK_B;
      end
      ST_CHK_B: if (rdAck) begin
        if (!toggled) begin
          ctl.finish = 1'b1;
          ctl.code   = RES_OK;
          nextState  = ST_IDLE;
        end else begin
          nextState = ST_RST_WR;
        end
      end
      ST_RST_WR: if (wrAck) begin
        ctl.finish = 1'b1;
        ctl.code   = RES_DEVERR;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    if (abort) begin
      ctl       = '0;
      nextState = ST_IDLE;
    end
  end

  assign rdReq = (state == ST_RD_A) || (state == ST_RD_B) ||
                 (state == ST_CHK_A) || (state == ST_CHK_B);
  assign wrReq = (state == ST_RST_WR);
  assign busy  = (state != ST_IDLE);

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN) abort |=> !busy);
  // R2
  launch_read_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> rdReq);
  // R6
  write_after_chk_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrReq) |-> $past(state == ST_CHK_B));

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import toggle_poll_pkg::*;
#(
  parameter int DW         = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int FAIL_BIT   = 5,
  parameter int POLL_LIMIT = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          abort,
  output logic          rdReq,
  input  logic          rdAck,
  input  logic [DW-1:0] rdData,
  output logic          wrReq,
  input  logic          wrAck,
  output logic [DW-1:0] wrData,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic          arrayReadOk
);

  dpCtl_t   ctl;
  logic     toggled, failBitHi, limitHit;
  pollRes_e resCode;

  toggle_poll_fsm u_fsm (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort),
    .rdAck(rdAck), .wrAck(wrAck), .toggled(toggled),
    .failBitHi(failBitHi), .limitHit(limitHit), .ctl(ctl),
    .rdReq(rdReq), .wrReq(wrReq), .busy(busy)
  );

  toggle_poll_dp #(
    .DW(DW), .TOGGLE_BIT(TOGGLE_BIT), .FAIL_BIT(FAIL_BIT), .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(rdData),
    .toggled(toggled), .failBitHi(failBitHi), .limitHit(limitHit),
    .done(done), .result(resCode), .arrayReadOk(arrayReadOk)
  );

  assign result = resCode;
  assign wrData = DW'(RESET_CMD);

  // R12
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(rdReq && wrReq));
  // R8
  abort_nodone_chk: assert property (@(posedge clk) disable iff (!rstN) abort |=> !done);
  // R6
  deverr_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && result == 2'b10) |-> $past(wrReq && wrAck));

endmodule

// File: tb/toggle_poll_ctrl_bench.sv
module toggle_poll_ctrl_bench;

  localparam int LIM = 3;

  typedef struct packed {
    logic [5:0][7:0] bytes;   // bytes[0] is read first
    logic [1:0]      expRes;
    logic [3:0]      expReads;
    logic            expWr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [0:NV-1] = '{
    '{{8'h00,8'h00,8'h00,8'h00,8'h40,8'h40}, 2'b01, 4'd2, 1'b0},  // R3
    '{{8'h00,8'h00,8'h00,8'h00,8'h40,8'h00}, 2'b01, 4'd4, 1'b0},  // R4
    '{{8'h00,8'h00,8'h00,8'h00,8'h20,8'h40}, 2'b01, 4'd4, 1'b0},  // R5
    '{{8'h00,8'h00,8'h00,8'h40,8'h20,8'h40}, 2'b10, 4'd4, 1'b1},  // R6
    '{{8'h00,8'h40,8'h00,8'h40,8'h00,8'h40}, 2'b11, 4'd6, 1'b0},  // R7
    '{{8'h00,8'h00,8'h00,8'h00,8'h40,8'h44}, 2'b01, 4'd2, 1'b0},  // R10
    '{{8'h00,8'h00,8'h60,8'h20,8'h40,8'h00}, 2'b01, 4'd6, 1'b0}   // R5
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0, abort = 1'b0;
  logic       rdReq, wrReq, busy, done, arrayReadOk;
  logic       rdAck = 1'b0, wrAck = 1'b0;
  logic [7:0] rdData = 8'h00, wrData;
  logic [1:0] result;

  int nChecks = 0, nFails = 0;
  int rdIdx = 0, wrCnt = 0, base = 0, wrBase = 0;
  logic [7:0] seqBuf [0:15];

  always #4 clk = ~clk;

  toggle_poll_ctrl #(.POLL_LIMIT(LIM)) u_toggle_poll_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort),
    .rdReq(rdReq), .rdAck(rdAck), .rdData(rdData),
    .wrReq(wrReq), .wrAck(wrAck), .wrData(wrData),
    .busy(busy), .done(done), .result(result), .arrayReadOk(arrayReadOk)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // handshake responders
  always @(negedge clk) begin
    if (!rstN) begin
      rdAck <= 1'b0;
      wrAck <= 1'b0;
    end else begin
      if (rdReq && !rdAck) begin
        rdAck  <= 1'b1;
        rdData <= seqBuf[(rdIdx - base) & 15];
        rdIdx  <= rdIdx + 1;
      end else rdAck <= 1'b0;
      if (wrReq && !wrAck) begin
        wrAck <= 1'b1;
        wrCnt <= wrCnt + 1;
        chk("R12 wrData", int'(wrData), 8'hF0);
      end else wrAck <= 1'b0;
      if (rdReq && wrReq) chk("R12 exclusive", 1, 0);
    end
  end

  task automatic loadVec(input vec_t v);
    for (int i = 0; i < 16; i++) seqBuf[i] = (i < 6) ? v.bytes[i] : ((i % 2) ? 8'h00 : 8'h40);
    base = rdIdx;
    wrBase = wrCnt;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone(output bit got);
    got = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
  endtask

  task automatic runVec(input vec_t v, input string tag, input bit extraStart);
    bit got;
    loadVec(v);
    pulseStart();
    chk({tag, " R3 ok cleared on start"}, int'(arrayReadOk), 0);
    chk({tag, " R2 busy"}, int'(busy), 1);
    if (extraStart) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    waitDone(got);
    chk({tag, " done seen"}, int'(got), 1);
    chk({tag, " result"}, int'(result), int'(v.expRes));
    chk({tag, " reads"}, rdIdx - base, int'(v.expReads));
    chk({tag, " writes"}, wrCnt - wrBase, int'(v.expWr));
    chk({tag, " R3 arrayReadOk"}, int'(arrayReadOk), int'(v.expRes == 2'b01));
    @(negedge clk);
    chk({tag, " R11 done one cycle"}, int'(done), 0);
    chk({tag, " R11 result held"}, int'(result), int'(v.expRes));
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 rdReq", int'(rdReq), 0);
    chk("R1 wrReq", int'(wrReq), 0);
    chk("R1 arrayReadOk", int'(arrayReadOk), 0);
    chk("R1 result", int'(result), 0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], $sformatf("vec%0d", i), 1'b0);

    // R11: start while busy ignored
    runVec(VECS[1], "R11 restart ignored", 1'b1);

    // R8: abort mid-poll
    v = VECS[4];
    loadVec(v);
    pulseStart();
    while (rdIdx - base < 3) @(negedge clk);
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    chk("R8 busy after abort", int'(busy), 0);
    chk("R8 rdReq after abort", int'(rdReq), 0);
    begin
      int seen = 0;
      repeat (10) begin @(negedge clk); if (done) seen++; end
      chk("R8 no done after abort", seen, 0);
    end

    // R9: fresh poll gets full budget
    runVec(VECS[4], "R9 fresh after abort", 1'b0);

    // R8: abort in the cycle of the completing acknowledge
    v = VECS[0];
    loadVec(v);
    pulseStart();
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      #1;
      if (rdAck && (rdIdx - base == 2)) break;
    end
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    begin
      int seen = 0;
      if (done) seen++;
      repeat (6) begin @(negedge clk); if (done) seen++; end
      chk("R8 abort beats completion done", seen, 0);
      chk("R8 abort beats completion ok", int'(arrayReadOk), 0);
      chk("R8 abort beats completion busy", int'(busy), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule